// File: doc/BRIEF.md
# Transmit Character Selector with 8B/10B Encoder

This block produces one 10-bit line character on every character clock. Each cycle a fixed-priority selector picks one source. A buffer error forces a code-violation character. An active word-sync burst sends K28.5. An enabled self-test generator sends pseudo-random data. Otherwise the input character is used: it is either encoded or passed through as a pre-encoded 10-bit word. Every encoded character goes through a running-disparity 8B/10B encoder.

The character leaves through a single output register, so an input sampled at a clock edge appears on `char_o` after that edge. Bit 0 of `char_o` is the first bit a downstream serializer puts on the line. In the standard 6b/4b naming, bits 0..5 carry a,b,c,d,e,i and bits 6..9 carry f,g,h,j. A data byte's bits 4..0 form the 5-bit half (x) and bits 7..5 form the 3-bit half (y).

Top module: `tx_char_sel`

## Requirements
- R1: While `rst_ni` is low, `char_o` is 0. The running disparity starts negative, so the first encoded character after reset uses its negative-disparity form (D0.0 gives 10'b0010111001).
- R2: With `enc_en_i`=0 and no higher-priority source, the next `char_o` is {`ctrl_i`,`data_i`}, with `data_i` in bits 0..7 and `ctrl_i` in bits 8..9. Control code 11 starts no word-sync burst in this mode.
- R3: With `enc_en_i`=1 and `ctrl_i`=00, `data_i` is sent as the 8B/10B data character Dx.y, including the alternate x.7 form chosen by disparity.
- R4: With `ctrl_i`=01, `data_i` is sent as a special character when it is K28.0–K28.7 (0x1C + 32·y), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) or K30.7 (0xFE). Any other byte gives the violation character and leaves the disparity unchanged.
- R5: With `ctrl_i`=10, one K28.5 is sent (10'h17C from negative disparity, 10'h283 from positive) and `data_i` is ignored.
- R6: Each encoded character flips the running disparity exactly when its count of ones is not 5. A character sent from negative disparity never has 4 ones, and one sent from positive disparity never has 6. Bypassed and violation characters leave the disparity unchanged.
- R7: While `buf_err_i` is 1, the next `char_o` is the violation character 10'b0000111111, whatever the other inputs are. The disparity is unchanged.
- R8: A word-sync burst starts on `wsync_req_i`=1, or on `ctrl_i`=11 in encoded mode with self-test off, provided no burst is running and `buf_err_i` is 0. It occupies 16 consecutive character slots of K28.5. Input characters and further requests are dropped while it runs.
- R9: With `bist_en_i`=1, data characters come from a 9-bit LFSR (x^9+x^5+1, next = {s[7:0], s[8]^s[4]}), byte = s[7:0], seed 9'h1FF. The sequence repeats every 511 characters. The LFSR is reloaded with the seed whenever `bist_en_i` is 0, and it does not advance in slots taken by a higher-priority source.
- R10: Source priority, highest first: violation (`buf_err_i`), word-sync burst, self-test, then the normal input path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data byte, or low 8 bits of a pre-encoded character |
| ctrl_i | input | 2 | Character control code, or high 2 bits of a pre-encoded character |
| enc_en_i | input | 1 | 1 selects encoding, 0 selects pass-through |
| bist_en_i | input | 1 | Self-test sequence enable |
| buf_err_i | input | 1 | Phase-align buffer error flag |
| wsync_req_i | input | 1 | Word-sync burst request |
| char_o | output | 10 | Line character, bit 0 sent first |

## Verification
The embedded properties assume that every input is synchronous to `clk_i` and stable around its rising edge. They also assume `buf_err_i` reflects an error in the slot it is sampled. The disparity properties rely only on the encoder being fed from the selector, never on a value the stimulus chooses. The bench changes inputs only on the falling edge and samples `char_o` shortly after the rising edge. Its own disparity and LFSR models advance only in slots that R6 and R9 say advance them.

// File: rtl/txcs_pkg.sv
`timescale 1ns/1ps
package txcs_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAR_W = 10;

  typedef enum logic [2:0] {SRC_VIOL, SRC_WSYNC, SRC_BIST, SRC_DATA, SRC_BYP} src_e;

  localparam logic [BYTE_W-1:0] K28_5_BYTE = 8'hBC;
  localparam logic [CHAR_W-1:0] VIOL_CHAR  = 10'b0000111111;
  localparam logic [CHAR_W-1:0] K285_NEG   = 10'h17C;
  localparam logic [CHAR_W-1:0] K285_POS   = 10'h283;

  function automatic logic [5:0] rev6(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[5-i];
    return r;
  endfunction

  function automatic logic [3:0] rev4(input logic [3:0] v);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = v[3-i];
    return r;
  endfunction

  // 5b/6b, written abcdei, negative-disparity form
  function automatic logic [5:0] sb6_neg(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;
      5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;
      5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;
      5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;
      5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;
      5'd9:  return 6'b100101;
      5'd10: return 6'b010101;
      5'd11: return 6'b110100;
      5'd12: return 6'b001101;
      5'd13: return 6'b101100;
      5'd14: return 6'b011100;
      5'd15: return 6'b010111;
      5'd16: return 6'b011011;
      5'd17: return 6'b100011;
      5'd18: return 6'b010011;
      5'd19: return 6'b110010;
      5'd20: return 6'b001011;
      5'd21: return 6'b101010;
      5'd22: return 6'b011010;
      5'd23: return 6'b111010;
      5'd24: return 6'b110011;
      5'd25: return 6'b100110;
      5'd26: return 6'b010110;
      5'd27: return 6'b110110;
      5'd28: return 6'b001110;
      5'd29: return 6'b101110;
      5'd30: return 6'b011110;
      default: return 6'b101011;
    endcase
  endfunction

  // 3b/4b data, written fghj, form used when disparity after 6b is negative
  function automatic logic [3:0] sb4_neg_d(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;
      3'd1: return 4'b1001;
      3'd2: return 4'b0101;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return 4'b1010;
      3'd6: return 4'b0110;
      default: return 4'b1110;
    endcase
  endfunction

  // 3b/4b for K28.y
  function automatic logic [3:0] sb4_neg_k(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;
      3'd1: return 4'b0110;
      3'd2: return 4'b1010;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return 4'b0101;
      3'd6: return 4'b1001;
      default: return 4'b0111;
    endcase
  endfunction
endpackage

// File: rtl/txcs_enc.sv
`timescale 1ns/1ps
module txcs_enc
  import txcs_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              k_i,
  input  logic              rd_i,
  output logic [CHAR_W-1:0] code_o,
  output logic              rd_o,
  output logic              legal_o
);
  logic [4:0] x;
  logic [2:0] y;
  logic       k28, alt7, rd6, flip6, flip4;
  logic [5:0] six, six_o;
  logic [3:0] four, four_o;

  always_comb begin
    x       = byte_i[4:0];
    y       = byte_i[7:5];
    k28     = k_i && (x == 5'd28);
    legal_o = !k_i || k28 ||
              ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));

    six   = k28 ? 6'b001111 : sb6_neg(x);
    // balanced codes keep their form except D7, which has two balanced forms
    flip6 = rd_i && (($countones(six) != 3) || (!k28 && x == 5'd7));
    six_o = flip6 ? ~six : six;
    rd6   = rd_i ^ ($countones(six) != 3);

    alt7 = (y == 3'd7) && (k_i ||
           (!rd_i && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           ( rd_i && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    if (k28)       four = sb4_neg_k(y);
    else if (alt7) four = 4'b0111;
    else           four = sb4_neg_d(y);
    flip4  = rd6 && (k28 || ($countones(four) != 2) || (y == 3'd3));
    four_o = flip4 ? ~four : four;

    rd_o   = rd6 ^ ($countones(four) != 2);
    code_o = {rev4(four_o), rev6(six_o)};
  end
endmodule

// File: rtl/txcs_lfsr.sv
`timescale 1ns/1ps
module txcs_lfsr #(
  parameter int             W     = 9,
  parameter int             TAP   = 5,
  parameter int             OUT_W = 8,
  parameter logic [W-1:0]   SEED  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             adv_i,
  output logic [OUT_W-1:0] byte_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= SEED;
    else if (!en_i)  st_q <= SEED;
    else if (adv_i)  st_q <= {st_q[W-2:0], st_q[W-1] ^ st_q[TAP-1]};
  end

  assign byte_o = st_q[OUT_W-1:0];

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);

  // R9
  lfsr_reseed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st_q == SEED);

  // R9
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> $stable(st_q));
endmodule

// File: rtl/txcs_wsync.sv
`timescale 1ns/1ps
module txcs_wsync #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LAST;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R8
  ws_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);

  // R8
  ws_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == LAST);
endmodule

// File: rtl/tx_char_sel.sv
`timescale 1ns/1ps
module tx_char_sel
  import txcs_pkg::*;
#(
  parameter int             WS_LEN    = 16,
  parameter int             LFSR_W    = 9,
  parameter int             LFSR_TAP  = 5,
  parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        ctrl_i,
  input  logic              enc_en_i,
  input  logic              bist_en_i,
  input  logic              buf_err_i,
  input  logic              wsync_req_i,
  output logic [CHAR_W-1:0] char_o
);
  src_e              src;
  logic              ws_active, ws_start, ctrl_ws;
  logic [BYTE_W-1:0] bist_byte, enc_byte;
  logic              enc_k, enc_rd, enc_legal;
  logic [CHAR_W-1:0] enc_code, char_d, char_q;
  logic              rd_d, rd_q, upd_d, upd_q;

  txcs_wsync #(.LEN(WS_LEN)) u_wsync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ws_start),
    .active_o (ws_active)
  );

  txcs_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .OUT_W(BYTE_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bist_en_i),
    .adv_i  (src == SRC_BIST),
    .byte_o (bist_byte)
  );

  txcs_enc u_enc (
    .byte_i  (enc_byte),
    .k_i     (enc_k),
    .rd_i    (rd_q),
    .code_o  (enc_code),
    .rd_o    (enc_rd),
    .legal_o (enc_legal)
  );

  always_comb begin
    ctrl_ws  = enc_en_i && !bist_en_i && (ctrl_i == 2'b11);
    ws_start = !buf_err_i && !ws_active && (wsync_req_i || ctrl_ws);

    if (buf_err_i)                  src = SRC_VIOL;
    else if (ws_active || ws_start) src = SRC_WSYNC;
    else if (bist_en_i)             src = SRC_BIST;
    else if (enc_en_i)              src = SRC_DATA;
    else                            src = SRC_BYP;

    enc_byte = K28_5_BYTE;
    enc_k    = 1'b1;
    if (src == SRC_BIST) begin
      enc_byte = bist_byte;
      enc_k    = 1'b0;
    end else if (src == SRC_DATA && !ctrl_i[1]) begin
      enc_byte = data_i;
      enc_k    = ctrl_i[0];
    end

    case (src)
      SRC_VIOL: begin char_d = VIOL_CHAR;         rd_d = rd_q; upd_d = 1'b0; end
      SRC_BYP:  begin char_d = {ctrl_i, data_i};  rd_d = rd_q; upd_d = 1'b0; end
      default: begin
        if (enc_legal) begin char_d = enc_code;  rd_d = enc_rd; upd_d = 1'b1; end
        else           begin char_d = VIOL_CHAR; rd_d = rd_q;   upd_d = 1'b0; end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q <= '0;
      rd_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      char_q <= char_d;
      rd_q   <= rd_d;
      upd_q  <= upd_d;
    end
  end

  assign char_o = char_q;

  // R7
  viol_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_err_i |=> char_o == VIOL_CHAR);

  // R7
  viol_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_err_i |=> rd_q == $past(rd_q));

  // R2
  byp_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_BYP) |=> char_o == $past({ctrl_i, data_i}));

  // R6
  rd_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (($past(rd_q) != rd_q) == ($countones(char_o) != 5)));

  // R6
  rd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> ($past(rd_q) ? ($countones(char_o) >= 4 && $countones(char_o) <= 5)
                           : ($countones(char_o) >= 5 && $countones(char_o) <= 6)));

  // R8
  ws_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src == SRC_WSYNC) |=> (char_o == K285_NEG || char_o == K285_POS));

  // R10
  prio_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_active && !buf_err_i) |-> src == SRC_WSYNC);
endmodule

// File: tb/tx_char_sel_tb.sv
`timescale 1ns/1ps
module tx_char_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] ctrl = '0;
  logic       enc_en = 1'b1, bist_en = 1'b0, buf_err = 1'b0, wsreq = 1'b0;
  logic [9:0] char_out;

  int         checks = 0;
  int         errors = 0;
  logic       rd_m;
  logic [8:0] lfsr_m;

  localparam logic [9:0] T_VIOL = 10'b0000111111;
  localparam logic [9:0] T_KN   = 10'h17C;
  localparam logic [9:0] T_KP   = 10'h283;

  always #10 clk = ~clk;

  tx_char_sel dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .data_i      (data),
    .ctrl_i      (ctrl),
    .enc_en_i    (enc_en),
    .bist_en_i   (bist_en),
    .buf_err_i   (buf_err),
    .wsync_req_i (wsreq),
    .char_o      (char_out)
  );

  // reference tables: {negative form, positive form}
  function automatic logic [11:0] tb6(input logic [4:0] x);
    case (x)
      5'd0:  return 12'b100111_011000;
      5'd1:  return 12'b011101_100010;
      5'd2:  return 12'b101101_010010;
      5'd3:  return 12'b110001_110001;
      5'd4:  return 12'b110101_001010;
      5'd5:  return 12'b101001_101001;
      5'd6:  return 12'b011001_011001;
      5'd7:  return 12'b111000_000111;
      5'd8:  return 12'b111001_000110;
      5'd9:  return 12'b100101_100101;
      5'd10: return 12'b010101_010101;
      5'd11: return 12'b110100_110100;
      5'd12: return 12'b001101_001101;
      5'd13: return 12'b101100_101100;
      5'd14: return 12'b011100_011100;
      5'd15: return 12'b010111_101000;
      5'd16: return 12'b011011_100100;
      5'd17: return 12'b100011_100011;
      5'd18: return 12'b010011_010011;
      5'd19: return 12'b110010_110010;
      5'd20: return 12'b001011_001011;
      5'd21: return 12'b101010_101010;
      5'd22: return 12'b011010_011010;
      5'd23: return 12'b111010_000101;
      5'd24: return 12'b110011_001100;
      5'd25: return 12'b100110_100110;
      5'd26: return 12'b010110_010110;
      5'd27: return 12'b110110_001001;
      5'd28: return 12'b001110_001110;
      5'd29: return 12'b101110_010001;
      5'd30: return 12'b011110_100001;
      default: return 12'b101011_010100;
    endcase
  endfunction

  function automatic logic [7:0] tb4(input logic [2:0] y);
    case (y)
      3'd0: return 8'b1011_0100;
      3'd1: return 8'b1001_1001;
      3'd2: return 8'b0101_0101;
      3'd3: return 8'b1100_0011;
      3'd4: return 8'b1101_0010;
      3'd5: return 8'b1010_1010;
      3'd6: return 8'b0110_0110;
      default: return 8'b1110_0001;
    endcase
  endfunction

  function automatic logic [7:0] tbk4(input logic [2:0] y);
    case (y)
      3'd0: return 8'b1011_0100;
      3'd1: return 8'b0110_1001;
      3'd2: return 8'b1010_0101;
      3'd3: return 8'b1100_0011;
      3'd4: return 8'b1101_0010;
      3'd5: return 8'b0101_1010;
      3'd6: return 8'b1001_0110;
      default: return 8'b0111_1000;
    endcase
  endfunction

  function automatic logic [5:0] trev6(input logic [5:0] v);
    return {v[0], v[1], v[2], v[3], v[4], v[5]};
  endfunction

  function automatic logic [3:0] trev4(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  function automatic logic tb_legal(input logic [7:0] b);
    return (b[4:0] == 5'd28) || (b == 8'hF7) || (b == 8'hFB) || (b == 8'hFD) || (b == 8'hFE);
  endfunction

  // returns {new disparity, character}
  function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rd);
    logic [4:0] x;
    logic [2:0] y;
    logic [11:0] t6;
    logic [7:0] t4;
    logic [5:0] s;
    logic [3:0] f;
    logic r6, a7;
    x  = b[4:0];
    y  = b[7:5];
    t6 = (k && x == 5'd28) ? 12'b001111_110000 : tb6(x);
    s  = rd ? t6[5:0] : t6[11:6];
    r6 = rd ^ ($countones(s) != 3);
    a7 = (y == 3'd7) && (k || (!rd && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                              (rd && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    if (k && x == 5'd28) t4 = tbk4(y);
    else if (a7)         t4 = 8'b0111_1000;
    else                 t4 = tb4(y);
    f = r6 ? t4[3:0] : t4[7:4];
    return {r6 ^ ($countones(f) != 2), trev4(f), trev6(s)};
  endfunction

  task automatic step(input logic [7:0] d, input logic [1:0] c, input logic en,
                      input logic bist, input logic err, input logic req);
    @(negedge clk);
    data = d; ctrl = c; enc_en = en; bist_en = bist; buf_err = err; wsreq = req;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: char_o=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic exp_enc(input string tag, input logic [7:0] b, input logic k);
    logic [10:0] r;
    r = ref_enc(b, k, rd_m);
    chk(tag, char_out, r[9:0]);
    rd_m = r[10];
  endtask

  task automatic exp_k285(input string tag);
    chk(tag, char_out, rd_m ? T_KP : T_KN);
    rd_m = ~rd_m;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset value", char_out, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    rd_m = 1'b0;
    step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 first D0.0 negative", char_out, 10'b0010111001);
    rd_m = 1'b0;
  endtask

  task automatic t_data;
    for (int i = 0; i < 256; i++) begin
      step(8'(i), 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
      exp_enc("R3 R6 data", 8'(i), 1'b0);
    end
    for (int i = 255; i >= 0; i -= 3) begin
      step(8'(i), 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
      exp_enc("R3 data reverse", 8'(i), 1'b0);
    end
  endtask

  task automatic t_bypass;
    step(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 bypass 3A5", char_out, 10'h3A5);
    step(8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 bypass 000", char_out, 10'h000);
    step(8'hFF, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 bypass 1FF", char_out, 10'h1FF);
    // disparity untouched and no burst started by code 11
    step(8'h00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_k285("R2 R6 rd kept across bypass");
    step(8'h0F, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R2 no burst after bypass 11", 8'h0F, 1'b0);
  endtask

  task automatic t_special;
    logic [7:0] b;
    for (int y = 0; y < 8; y++) begin
      b = {3'(y), 5'd28};
      step(b, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
      exp_enc("R4 K28.y", b, 1'b1);
    end
    foreach (b[i]) begin
      logic [7:0] kk;
      kk = (i == 0) ? 8'hF7 : (i == 1) ? 8'hFB : (i == 2) ? 8'hFD : 8'hFE;
      if (i < 4) begin
        step(kk, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        exp_enc("R4 Kx.7", kk, 1'b1);
      end
    end
    for (int i = 0; i < 256; i += 37) begin
      if (!tb_legal(8'(i))) begin
        step(8'(i), 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4 illegal special", char_out, T_VIOL);
      end
    end
    step(8'h05, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R4 R6 rd kept after illegal special", 8'h05, 1'b0);
  endtask

  task automatic t_k285;
    step(8'h00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_k285("R5 single K28.5 a");
    step(8'h55, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_k285("R5 single K28.5 b");
    step(8'hFF, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_k285("R5 single K28.5 c");
    step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R5 single only, then data", 8'h00, 1'b0);
  endtask

  task automatic t_viol;
    step(8'h12, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 violation encoded", char_out, T_VIOL);
    step(8'hA5, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 violation over bypass", char_out, T_VIOL);
    step(8'hBC, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 violation over special", char_out, T_VIOL);
    step(8'h03, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R7 R6 rd kept after violation", 8'h03, 1'b0);
  endtask

  task automatic t_wsync;
    step(8'h00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_k285("R8 burst slot 0");
    for (int i = 1; i < 16; i++) begin
      step(8'h44, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
      exp_k285("R8 burst slot");
    end
    step(8'h44, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R8 burst ends after 16", 8'h44, 1'b0);
    step(8'h05, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    exp_k285("R8 request in bypass slot 0");
    for (int i = 1; i < 16; i++) begin
      step(8'h05, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
      exp_k285("R8 request burst slot");
    end
    step(8'h05, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 R2 bypass resumes", char_out, 10'h005);
  endtask

  task automatic t_bist;
    lfsr_m = 9'h1FF;
    for (int i = 0; i < 600; i++) begin
      step(8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      exp_enc("R9 self-test sequence", lfsr_m[7:0], 1'b0);
      lfsr_m = {lfsr_m[7:0], lfsr_m[8] ^ lfsr_m[4]};
    end
    step(8'h3C, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R9 off gives normal data", 8'h3C, 1'b0);
    step(8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    exp_enc("R9 restart at seed", 8'hFF, 1'b0);
    step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R9 off again", 8'h00, 1'b0);
  endtask

  task automatic t_prio;
    lfsr_m = 9'h1FF;
    for (int i = 0; i < 3; i++) begin
      step(8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      exp_enc("R10 self-test before burst", lfsr_m[7:0], 1'b0);
      lfsr_m = {lfsr_m[7:0], lfsr_m[8] ^ lfsr_m[4]};
    end
    for (int i = 0; i < 16; i++) begin
      step(8'h00, 2'b00, 1'b1, 1'b1, (i == 5 || i == 6), (i == 0 || i == 9));
      if (i == 5 || i == 6) chk("R10 violation over burst", char_out, T_VIOL);
      else                  exp_k285("R10 burst over self-test");
    end
    step(8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    exp_enc("R10 R9 self-test resumes unadvanced", lfsr_m[7:0], 1'b0);
    lfsr_m = {lfsr_m[7:0], lfsr_m[8] ^ lfsr_m[4]};
    step(8'h00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R10 violation with request", char_out, T_VIOL);
    step(8'h00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    exp_enc("R10 R8 request under error dropped", lfsr_m[7:0], 1'b0);
    step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    exp_enc("R10 normal path lowest", 8'h00, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_data();
    t_bypass();
    t_special();
    t_k285();
    t_viol();
    t_wsync();
    t_bist();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule